// File: doc/BRIEF.md
# Port Control Line Handshake and Interrupt Unit

This block manages the two control lines on each side of a two-port parallel interface. On each port, the first control line (C1) is an input only. The second line (C2) is an input or an output, chosen by the port's control register. The block watches the incoming lines for the edge the software selected and latches interrupt flags from those edges. It merges each port's flags with their enable bits into one active-high interrupt request per port. When C2 is an output, the block drives it in one of three ways: a steady level taken from the control register, a one-cycle low strobe, or a low strobe held until the next active C1 edge.

The two ports differ in what starts the strobe. Port A strobes on a read of its data register. Port B strobes on a write of its data register. Port B has one extra rule: if a data read finds its C1 flag already set while it is in held-strobe mode, CB2 returns high.

The block does no bus decoding. It receives the current control register contents and one-cycle event pulses from the register interface. The external C1 and C2 inputs are resynchronised before any edge detection.

Top module: `ctl_handshake_unit`

## Requirements
- R1: After reset both ports show every flag at 0, both interrupt requests at 0, and both C2 outputs high.
- R2: The C1 flag sets only on a C1 change in the direction given by control bit 1 (1 = low-to-high, 0 = high-to-low). The opposite change leaves the flag alone. The flag is visible on the third rising clock edge after the pin changes.
- R3: With control bit 5 at 0 (C2 is an input), the C2 flag sets on the C2 edge chosen by control bit 4 (1 = low-to-high, 0 = high-to-low). It uses the same latency as R2.
- R4: With control bit 5 at 1 (C2 is an output), the C2 flag neither sets nor reads as 1.
- R5: The interrupt request equals (C1 flag AND control bit 0) OR (C2 flag AND control bit 3 AND C2 is an input). It follows the flag in the same cycle.
- R6: A data read pulse clears both flags of its own port on the next edge. If a new active C1 edge arrives in the same cycle, the set wins.
- R7: With control bits 5 and 4 both at 1, a control write pulse drives C2 to the value of control bit 3 on the next edge. A change of the control contents without the write pulse leaves C2 unchanged. The C2 output enable follows bit 5.
- R8: On port A in strobe mode (bit 5 = 1, bit 4 = 0), a data read pulse drives CA2 low on the next edge.
- R9: On port B in strobe mode, a data write pulse drives CB2 low on the next edge. A data read with the C1 flag clear does not.
- R10: In strobe mode with control bit 3 at 1, C2 is low for exactly one cycle and then returns high.
- R11: In strobe mode with control bit 3 at 0, C2 stays low until the next active C1 edge. That edge drives C2 high and sets the C1 flag on the same clock edge.
- R12: On port B in strobe mode with bit 3 at 0, a data read that finds the C1 flag set drives CB2 high. On port A, a read under the same conditions strobes CA2 low instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_a | input | 6 | Port A control register contents |
| ctrl_a_wr | input | 1 | Port A control register write pulse |
| data_a_rd | input | 1 | Port A data register read pulse |
| c1_a | input | 1 | Port A C1 line, asynchronous |
| c2_a_in | input | 1 | Port A C2 line as input, asynchronous |
| flag1_a | output | 1 | Port A C1 interrupt flag |
| flag2_a | output | 1 | Port A C2 interrupt flag |
| irq_a | output | 1 | Port A interrupt request, active high |
| c2_a_out | output | 1 | Port A C2 drive value |
| c2_a_oe | output | 1 | Port A C2 output enable |
| ctrl_b | input | 6 | Port B control register contents |
| ctrl_b_wr | input | 1 | Port B control register write pulse |
| data_b_rd | input | 1 | Port B data register read pulse |
| data_b_wr | input | 1 | Port B data register write pulse |
| c1_b | input | 1 | Port B C1 line, asynchronous |
| c2_b_in | input | 1 | Port B C2 line as input, asynchronous |
| flag1_b | output | 1 | Port B C1 interrupt flag |
| flag2_b | output | 1 | Port B C2 interrupt flag |
| irq_b | output | 1 | Port B interrupt request, active high |
| c2_b_out | output | 1 | Port B C2 drive value |
| c2_b_oe | output | 1 | Port B C2 output enable |

## Verification
A pin change reaches its flag and interrupt request three rising edges after it is applied: two synchroniser stages, then the flag register. The bench samples at the falling edge after the second rising edge to confirm the flag is still clear, and again after the third to confirm it has set. Event pulses and control writes change C2 or clear flags on the first rising edge. The bench therefore checks at the falling edge right after that edge, and for the one-cycle strobe it checks again one cycle later for the return high. All stimulus is applied and all outputs are read at falling edges, so no rising edge can race a sample.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
   // control register width and field positions (decoded by the port logic)
   localparam int CTL_W      = 6;
   localparam int B_C1_IE    = 0;  // C1 interrupt enable
   localparam int B_C1_RISE  = 1;  // C1 active edge: 1 rising, 0 falling
   localparam int B_C2_AUX   = 3;  // input: C2 irq enable; output: level or restore select
   localparam int B_C2_MODE  = 4;  // input: C2 edge select; output: 1 level, 0 strobe
   localparam int B_C2_DIR   = 5;  // 1 = C2 is an output

   typedef enum logic [1:0] {
      C2_INPUT     = 2'd0,
      C2_LEVEL     = 2'd1,
      C2_STROBE_E  = 2'd2,
      C2_STROBE_C1 = 2'd3
   } c2_use_e;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsk_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{IDLE}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsk_edge.sv
module hsk_edge #(
   parameter logic IDLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_sel,
   output logic hit
);
   logic prev;
   logic rose, fell;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE;
      else        prev <= lvl;
   end

   assign rose = lvl & ~prev;
   assign fell = ~lvl & prev;
   assign hit  = rise_sel ? rose : fell;
endmodule

// File: rtl/hsk_port.sv
module hsk_port
   import hsk_pkg::*;
#(
   parameter int   SYNC_STAGES   = 2,
   parameter logic IDLE_LEVEL    = 1'b0,
   parameter bit   CLEAR_RELEASE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctrl,
   input  logic             ctrl_wr,
   input  logic             data_rd,
   input  logic             strobe_evt,
   input  logic             c1_pin,
   input  logic             c2_pin,
   output logic             flag1,
   output logic             flag2,
   output logic             irq,
   output logic             c2_out,
   output logic             c2_oe
);
   logic    c1_s, c2_s, c1_hit, c2_hit;
   logic    f1_q, f2_q, c2_q;
   logic    f1_d, f2_d, c2_d;
   logic    release_rd;
   c2_use_e use_c2;
   logic    unused_ctl_bit;

   assign unused_ctl_bit = ctrl[2];

   always_comb begin
      if (!ctrl[B_C2_DIR])     use_c2 = C2_INPUT;
      else if (ctrl[B_C2_MODE]) use_c2 = C2_LEVEL;
      else if (ctrl[B_C2_AUX])  use_c2 = C2_STROBE_E;
      else                      use_c2 = C2_STROBE_C1;
   end

   hsk_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE_LEVEL)) u_sync_c1 (
      .clk(clk), .rst_n(rst_n), .d(c1_pin), .q(c1_s));
   hsk_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE_LEVEL)) u_sync_c2 (
      .clk(clk), .rst_n(rst_n), .d(c2_pin), .q(c2_s));

   hsk_edge #(.IDLE(IDLE_LEVEL)) u_edge_c1 (
      .clk(clk), .rst_n(rst_n), .lvl(c1_s), .rise_sel(ctrl[B_C1_RISE]), .hit(c1_hit));
   hsk_edge #(.IDLE(IDLE_LEVEL)) u_edge_c2 (
      .clk(clk), .rst_n(rst_n), .lvl(c2_s), .rise_sel(ctrl[B_C2_MODE]), .hit(c2_hit));

   generate
      if (CLEAR_RELEASE) begin : g_release
         assign release_rd = data_rd & f1_q & (use_c2 == C2_STROBE_C1);
      end else begin : g_no_release
         assign release_rd = 1'b0;
      end
   endgenerate

   always_comb begin
      f1_d = f1_q;
      if (data_rd) f1_d = 1'b0;
      if (c1_hit)  f1_d = 1'b1;

      f2_d = f2_q;
      if (data_rd) f2_d = 1'b0;
      if (c2_hit && use_c2 == C2_INPUT) f2_d = 1'b1;
      if (use_c2 != C2_INPUT) f2_d = 1'b0;
   end

   always_comb begin
      c2_d = c2_q;
      if (use_c2 == C2_STROBE_C1 && c1_hit) c2_d = 1'b1;
      if (release_rd)                       c2_d = 1'b1;
      if (use_c2 == C2_STROBE_E && !c2_q)   c2_d = 1'b1;
      if ((use_c2 == C2_STROBE_E || use_c2 == C2_STROBE_C1) && strobe_evt) c2_d = 1'b0;
      if (ctrl_wr && use_c2 == C2_LEVEL)    c2_d = ctrl[B_C2_AUX];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f1_q <= 1'b0;
         f2_q <= 1'b0;
         c2_q <= 1'b1;
      end else begin
         f1_q <= f1_d;
         f2_q <= f2_d;
         c2_q <= c2_d;
      end
   end

   assign flag1  = f1_q;
   assign flag2  = f2_q & (use_c2 == C2_INPUT);
   assign irq    = (f1_q & ctrl[B_C1_IE]) | (f2_q & ctrl[B_C2_AUX] & (use_c2 == C2_INPUT));
   assign c2_out = c2_q;
   assign c2_oe  = ctrl[B_C2_DIR];

   // R2: an active C1 edge always leaves the flag set
   a_r2_c1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      c1_hit |=> flag1);
   // R4: no C2 flag while C2 drives
   a_r4_c2_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[B_C2_DIR] |=> !f2_q);
   // R6: a read with no new edge clears the C1 flag
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !c1_hit) |=> !flag1);
   // R7: level write lands on the pin
   a_r7_level_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl[B_C2_DIR] && ctrl[B_C2_MODE]) |=> (c2_out == $past(ctrl[B_C2_AUX])));
   // R10: a strobe event pulls C2 low
   a_r10_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[B_C2_DIR] && !ctrl[B_C2_MODE] && strobe_evt) |=> !c2_out);
   // R10: the one-cycle strobe comes back high
   a_r10_e_return: assert property (@(posedge clk) disable iff (!rst_n)
      (use_c2 == C2_STROBE_E && !c2_out && !strobe_evt) |=> c2_out);
   // R11: the active C1 edge releases the held strobe
   a_r11_c1_release: assert property (@(posedge clk) disable iff (!rst_n)
      (use_c2 == C2_STROBE_C1 && c1_hit && !strobe_evt) |=> c2_out);
endmodule

// File: rtl/ctl_handshake_unit.sv
module ctl_handshake_unit #(
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [hsk_pkg::CTL_W-1:0] ctrl_a,
   input  logic                     ctrl_a_wr,
   input  logic                     data_a_rd,
   input  logic                     c1_a,
   input  logic                     c2_a_in,
   output logic                     flag1_a,
   output logic                     flag2_a,
   output logic                     irq_a,
   output logic                     c2_a_out,
   output logic                     c2_a_oe,
   input  logic [hsk_pkg::CTL_W-1:0] ctrl_b,
   input  logic                     ctrl_b_wr,
   input  logic                     data_b_rd,
   input  logic                     data_b_wr,
   input  logic                     c1_b,
   input  logic                     c2_b_in,
   output logic                     flag1_b,
   output logic                     flag2_b,
   output logic                     irq_b,
   output logic                     c2_b_out,
   output logic                     c2_b_oe
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ctl_handshake_unit: SYNC_STAGES must be 2 or more");
      end
   endgenerate

   // port A strobes on data reads
   hsk_port #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL), .CLEAR_RELEASE(1'b0)) u_port_a (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl_a), .ctrl_wr(ctrl_a_wr),
      .data_rd(data_a_rd), .strobe_evt(data_a_rd),
      .c1_pin(c1_a), .c2_pin(c2_a_in),
      .flag1(flag1_a), .flag2(flag2_a), .irq(irq_a),
      .c2_out(c2_a_out), .c2_oe(c2_a_oe));

   // port B strobes on data writes and releases on a flagged read
   hsk_port #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL), .CLEAR_RELEASE(1'b1)) u_port_b (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl_b), .ctrl_wr(ctrl_b_wr),
      .data_rd(data_b_rd), .strobe_evt(data_b_wr),
      .c1_pin(c1_b), .c2_pin(c2_b_in),
      .flag1(flag1_b), .flag2(flag2_b), .irq(irq_b),
      .c2_out(c2_b_out), .c2_oe(c2_b_oe));
endmodule

// File: tb/sim_ctl_handshake_unit.sv
`timescale 1ns/1ps
module sim_ctl_handshake_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0] ctl [2];
   logic cwr [2];
   logic drd [2];
   logic dwr_b;
   logic c1 [2];
   logic c2i [2];
   logic f1 [2];
   logic f2 [2];
   logic irq [2];
   logic c2o [2];
   logic oe [2];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 0;

   always #2 clk = ~clk;

   ctl_handshake_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .ctrl_a(ctl[0]), .ctrl_a_wr(cwr[0]), .data_a_rd(drd[0]),
      .c1_a(c1[0]), .c2_a_in(c2i[0]),
      .flag1_a(f1[0]), .flag2_a(f2[0]), .irq_a(irq[0]), .c2_a_out(c2o[0]), .c2_a_oe(oe[0]),
      .ctrl_b(ctl[1]), .ctrl_b_wr(cwr[1]), .data_b_rd(drd[1]), .data_b_wr(dwr_b),
      .c1_b(c1[1]), .c2_b_in(c2i[1]),
      .flag1_b(f1[1]), .flag2_b(f2[1]), .irq_b(irq[1]), .c2_b_out(c2o[1]), .c2_b_oe(oe[1]));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wctl(input int p, input logic [5:0] v);
      ctl[p] = v; cwr[p] = 1'b1; step(1); cwr[p] = 1'b0;
   endtask

   task automatic rd(input int p);
      drd[p] = 1'b1; step(1); drd[p] = 1'b0;
   endtask

   task automatic wr_b();
      dwr_b = 1'b1; step(1); dwr_b = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1 (run finished)");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 2; p++) begin
         ctl[p] = 6'd0; cwr[p] = 0; drd[p] = 0; c1[p] = 0; c2i[p] = 0;
      end
      dwr_b = 0;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      for (int p = 0; p < 2; p++) begin
         chk("R1", "flag1", f1[p], 0);
         chk("R1", "flag2", f2[p], 0);
         chk("R1", "irq", irq[p], 0);
         chk("R1", "c2_out", c2o[p], 1);
      end

      // R2 / R5 / R6: C1 edge sweep over edge select, enable and direction
      for (int p = 0; p < 2; p++)
         for (int ie = 0; ie < 2; ie++)
            for (int rs = 0; rs < 2; rs++)
               for (int k = 0; k < 2; k++) begin
                  logic lv;
                  int   e;
                  lv = (k == 0);
                  wctl(p, {4'b0000, rs[0], ie[0]});
                  rd(p);
                  c1[p] = lv;
                  step(2);
                  chk("R2", "flag1 before latency", f1[p], 0);
                  step(1);
                  e = (lv == rs[0]) ? 1 : 0;
                  chk("R2", "flag1 after edge", f1[p], e);
                  chk("R5", "irq from C1", irq[p], e * ie);
                  if (e == 1) begin
                     rd(p);
                     chk("R6", "flag1 cleared by read", f1[p], 0);
                  end
               end

      // R3 / R4 / R5: C2 edge sweep over direction and edge select
      for (int p = 0; p < 2; p++)
         for (int dir = 0; dir < 2; dir++)
            for (int es = 0; es < 2; es++)
               for (int k = 0; k < 2; k++) begin
                  logic lv;
                  int   e;
                  lv = (k == 0);
                  wctl(p, {dir[0], es[0], 1'b1, 3'b000});
                  rd(p);
                  c2i[p] = lv;
                  step(3);
                  e = (dir == 0 && lv == es[0]) ? 1 : 0;
                  chk(dir == 0 ? "R3" : "R4", "flag2", f2[p], e);
                  chk("R5", "irq from C2", irq[p], e);
               end

      // R7: level mode, only a write moves C2
      for (int p = 0; p < 2; p++) begin
         int prev;
         prev = c2o[p];
         for (int k = 0; k < 2; k++) begin
            ctl[p] = {2'b11, k[0], 3'b000};
            step(1);
            chk("R7", "no write, no change", c2o[p], prev);
            wctl(p, {2'b11, k[0], 3'b000});
            chk("R7", "level after write", c2o[p], k);
            chk("R7", "output enable", oe[p], 1);
            prev = k;
         end
      end

      // R8 / R10: port A one-cycle read strobe
      wctl(0, 6'b101000);
      chk("R8", "CA2 idle high", c2o[0], 1);
      rd(0);
      chk("R8", "CA2 low after read", c2o[0], 0);
      step(1);
      chk("R10", "CA2 back high", c2o[0], 1);

      // R9 / R10: port B one-cycle write strobe
      wctl(1, 6'b101000);
      rd(1);
      chk("R9", "CB2 unaffected by read", c2o[1], 1);
      wr_b();
      chk("R9", "CB2 low after write", c2o[1], 0);
      step(1);
      chk("R10", "CB2 back high", c2o[1], 1);

      // R11: held strobe released by rising C1
      wctl(0, 6'b100011);
      wctl(1, 6'b100011);
      rd(0);
      rd(1);
      wr_b();
      step(5);
      chk("R11", "CA2 held low", c2o[0], 0);
      chk("R11", "CB2 held low", c2o[1], 0);
      c1[0] = 1'b1; c1[1] = 1'b1;
      step(2);
      chk("R11", "CA2 low before C1 arrives", c2o[0], 0);
      chk("R11", "CB2 low before C1 arrives", c2o[1], 0);
      step(1);
      for (int p = 0; p < 2; p++) begin
         chk("R11", "C2 released", c2o[p], 1);
         chk("R11", "C1 flag set", f1[p], 1);
         chk("R11", "irq", irq[p], 1);
      end

      // R12: flagged read on port B releases CB2; port A strobes instead
      wr_b();
      chk("R12", "CB2 low after write", c2o[1], 0);
      chk("R12", "flag1 B still set", f1[1], 1);
      rd(1);
      chk("R12", "CB2 high after flagged read", c2o[1], 1);
      chk("R12", "flag1 B cleared", f1[1], 0);
      rd(0);
      chk("R12", "CA2 low after flagged read", c2o[0], 0);
      chk("R12", "flag1 A cleared", f1[0], 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule